// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core through four power modes and owns the enable signals for each clock domain around it. Full-speed operation is the home mode. Three low-power modes can be requested: a light one that only stops the core clock, a deeper one that also stops the peripheral bus clock and puts DRAM into self-refresh, and a deepest one that stops every clock. Each low-power mode has its own set of wake events. The controller runs on an always-on slow clock, so it can see wake events even when every gated domain is stopped.

A mode request is a one-cycle strobe that is raised when the matching instruction retires. Entry is a short ordered sequence: stall the pipeline, drain the system bus where needed, and then gate clocks. Exit is one common ramp that turns the domains back on one at a time. The PLL comes up first and the core clock last, with a programmable number of cycles between steps. The pipeline stall is released at the very end. All outputs come straight from registers.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and just after it, the controller is in full speed: all six clock enables are 1, stall_o and sref_req_o are 0, and mode_o is 2'b00.
- R2: mode_o reports the mode as 00 full speed, 01 standby, 10 suspend, 11 hibernate. The new code appears in the first cycle of an entry sequence and stays until the wake ramp finishes.
- R3: A standby strobe raises stall_o in the next cycle. In the cycle after that, core_clk_en_o goes low and every other clock enable stays high.
- R4: In standby, irq_i or wut_irq_i starts the wake ramp.
- R5: A suspend strobe raises stall_o. One cycle later pbus_clk_en_o goes low. The controller then waits for bus_idle_i. One cycle after it samples bus_idle_i high, sref_req_o goes high, and one cycle after that core_clk_en_o goes low.
- R6: In suspend, the PLL, timer, interrupt and master clock enables stay high, and irq_i or wut_irq_i starts the wake ramp.
- R7: A hibernate strobe raises stall_o, then drops pbus_clk_en_o and waits for bus_idle_i. Once the bus is idle, all six clock enables go low together.
- R8: In hibernate, only pwr_btn_i or wut_irq_i starts the wake ramp. irq_i alone leaves the controller in hibernate.
- R9: The wake ramp takes one step every WAKE_GAP cycles. The steps, in order, are: PLL on, timer and interrupt clocks on, master clock on, peripheral bus clock on, sref_req_o low, core clock on, and finally stall_o low together with mode_o back to 00.
- R10: Mode strobes have no effect unless the controller is in full speed. This covers the entry sequences, the low-power modes and the wake ramp.
- R11: If strobes coincide, hibernate takes priority over suspend, and suspend takes priority over standby.
- R12: Wake inputs are acted on only once the low-power mode is fully entered. A wake input held high during an entry sequence starts the ramp in the first cycle after entry completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_stby_i | input | 1 | One-cycle standby request strobe |
| req_susp_i | input | 1 | One-cycle suspend request strobe |
| req_hibr_i | input | 1 | One-cycle hibernate request strobe |
| bus_idle_i | input | 1 | Internal system bus is idle |
| irq_i | input | 1 | Ordinary interrupt request |
| pwr_btn_i | input | 1 | Power button asserted |
| wut_irq_i | input | 1 | Wake-up timer interrupt |
| core_clk_en_o | output | 1 | Core clock gate enable |
| tmr_clk_en_o | output | 1 | Timer clock gate enable |
| int_clk_en_o | output | 1 | Interrupt-logic clock gate enable |
| pll_en_o | output | 1 | PLL enable |
| pbus_clk_en_o | output | 1 | Peripheral bus clock gate enable |
| mclk_en_o | output | 1 | Master clock output enable |
| sref_req_o | output | 1 | DRAM self-refresh request |
| stall_o | output | 1 | Pipeline stall |
| mode_o | output | 2 | Current mode code |

## Verification
The cases that are hardest to reach from the ports are the overlaps: a wake input that is already high while an entry sequence is still running, and new strobes that arrive while a wake ramp is in progress. The stimulus produces these by raising irq_i in the same cycle as a suspend strobe and holding it through the bus drain, and by firing all three strobes during the ramp. In hibernate, irq_i is pulsed and held for several cycles before the power button is pressed. The bench builds the ramp with a gap of two cycles, so each step's spacing is visible at the ports.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_FULL = 2'b00,
    PM_STBY = 2'b01,
    PM_SUSP = 2'b10,
    PM_HIBR = 2'b11
  } pm_mode_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_SB_STALL,
    ST_SB_HOLD,
    ST_SP_STALL,
    ST_SP_DRAIN,
    ST_SP_SREF,
    ST_SP_HOLD,
    ST_HB_STALL,
    ST_HB_DRAIN,
    ST_HB_HOLD,
    ST_WAKE
  } pmc_state_e;

  // clock-enable vector bit positions
  localparam int CK_CORE = 0;
  localparam int CK_TMR  = 1;
  localparam int CK_INT  = 2;
  localparam int CK_PLL  = 3;
  localparam int CK_PBUS = 4;
  localparam int CK_MCLK = 5;
  localparam int CK_N    = 6;

  // wake ramp step count (0 .. WAKE_LAST)
  localparam int WAKE_LAST = 6;
  localparam int STEP_W    = $clog2(WAKE_LAST + 1);

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/pmc_req_arb.sv
module pmc_req_arb
  import pmc_pkg::*;
(
  input  logic     accept_i,
  input  logic     req_sb_i,
  input  logic     req_sp_i,
  input  logic     req_hb_i,
  output logic     vld_o,
  output pm_mode_e mode_o
);

  always_comb begin
    vld_o  = 1'b0;
    mode_o = PM_FULL;
    if (accept_i) begin
      if (req_hb_i) begin
        vld_o  = 1'b1;
        mode_o = PM_HIBR;
      end else if (req_sp_i) begin
        vld_o  = 1'b1;
        mode_o = PM_SUSP;
      end else if (req_sb_i) begin
        vld_o  = 1'b1;
        mode_o = PM_STBY;
      end
    end
  end

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int WAKE_GAP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld_i,
  input  pm_mode_e        req_mode_i,
  input  logic            bus_idle_i,
  input  logic            irq_i,
  input  logic            pwr_btn_i,
  input  logic            wut_irq_i,
  output logic            in_run_o,
  output logic [CK_N-1:0] clk_en_o,
  output logic            sref_o,
  output logic            stall_o,
  output pm_mode_e        mode_o
);

  localparam int GAP_W = (WAKE_GAP > 1) ? $clog2(WAKE_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(WAKE_GAP - 1);

  pmc_state_e        st_q, st_d;
  pm_mode_e          mode_q, mode_d;
  logic [CK_N-1:0]   en_q, en_d;
  logic              sref_q, sref_d;
  logic              stall_q, stall_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [STEP_W-1:0] step_nx;
  logic              wake_go;

  assign step_nx = step_q + STEP_W'(1);

  always_comb begin
    wake_go = 1'b0;
    unique case (st_q)
      ST_SB_HOLD, ST_SP_HOLD: wake_go = irq_i | wut_irq_i;
      ST_HB_HOLD:             wake_go = pwr_btn_i | wut_irq_i;
      default:                wake_go = 1'b0;
    endcase
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    en_d    = en_q;
    sref_d  = sref_q;
    stall_d = stall_q;
    step_d  = step_q;
    gap_d   = gap_q;
    if (wake_go) begin
      st_d         = ST_WAKE;
      step_d       = '0;
      gap_d        = '0;
      en_d[CK_PLL] = 1'b1;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (req_vld_i) begin
            mode_d  = req_mode_i;
            stall_d = 1'b1;
            unique case (req_mode_i)
              PM_HIBR: st_d = ST_HB_STALL;
              PM_SUSP: st_d = ST_SP_STALL;
              default: st_d = ST_SB_STALL;
            endcase
          end
        end
        ST_SB_STALL: begin
          en_d[CK_CORE] = 1'b0;
          st_d          = ST_SB_HOLD;
        end
        ST_SP_STALL: begin
          en_d[CK_PBUS] = 1'b0;
          st_d          = ST_SP_DRAIN;
        end
        ST_SP_DRAIN: begin
          if (bus_idle_i) begin
            sref_d = 1'b1;
            st_d   = ST_SP_SREF;
          end
        end
        ST_SP_SREF: begin
          en_d[CK_CORE] = 1'b0;
          st_d          = ST_SP_HOLD;
        end
        ST_HB_STALL: begin
          en_d[CK_PBUS] = 1'b0;
          st_d          = ST_HB_DRAIN;
        end
        ST_HB_DRAIN: begin
          if (bus_idle_i) begin
            en_d = '0;
            st_d = ST_HB_HOLD;
          end
        end
        ST_WAKE: begin
          if (gap_q == GAP_END) begin
            gap_d  = '0;
            step_d = step_nx;
            unique case (step_nx)
              STEP_W'(1): begin
                en_d[CK_TMR] = 1'b1;
                en_d[CK_INT] = 1'b1;
              end
              STEP_W'(2): en_d[CK_MCLK] = 1'b1;
              STEP_W'(3): en_d[CK_PBUS] = 1'b1;
              STEP_W'(4): sref_d        = 1'b0;
              STEP_W'(5): en_d[CK_CORE] = 1'b1;
              default: begin
                stall_d = 1'b0;
                mode_d  = PM_FULL;
                st_d    = ST_RUN;
              end
            endcase
          end else begin
            gap_d = gap_q + GAP_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      mode_q  <= PM_FULL;
      en_q    <= '1;
      sref_q  <= 1'b0;
      stall_q <= 1'b0;
      step_q  <= '0;
      gap_q   <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
      sref_q  <= sref_d;
      stall_q <= stall_d;
      step_q  <= step_d;
      gap_q   <= gap_d;
    end
  end

  assign in_run_o = (st_q == ST_RUN);
  assign clk_en_o = en_q;
  assign sref_o   = sref_q;
  assign stall_o  = stall_q;
  assign mode_o   = mode_q;

  // R9
  core_after_sref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q[CK_CORE]) |-> (stall_q && !sref_q && en_q[CK_PLL]));

  // R9
  stall_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_q) |-> ((&en_q) && !sref_q && mode_q == PM_FULL));

  // R5
  sref_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sref_q) |-> (!en_q[CK_PBUS] && stall_q && $past(bus_idle_i)));

  // R7
  pll_off_only_hib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[CK_PLL] |-> (en_q == '0 && mode_q == PM_HIBR));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_FULL && $past(mode_q) != PM_FULL) |-> (mode_q == $past(mode_q)));

  // R8
  hib_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HB_HOLD && !pwr_btn_i && !wut_irq_i) |=> (st_q == ST_HB_HOLD));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_GAP   = 1,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_stby_i,
  input  logic       req_susp_i,
  input  logic       req_hibr_i,
  input  logic       bus_idle_i,
  input  logic       irq_i,
  input  logic       pwr_btn_i,
  input  logic       wut_irq_i,
  output logic       core_clk_en_o,
  output logic       tmr_clk_en_o,
  output logic       int_clk_en_o,
  output logic       pll_en_o,
  output logic       pbus_clk_en_o,
  output logic       mclk_en_o,
  output logic       sref_req_o,
  output logic       stall_o,
  output logic [1:0] mode_o
);

  logic            srst_n;
  logic            in_run;
  logic            req_vld;
  pm_mode_e        req_mode;
  pm_mode_e        cur_mode;
  logic [CK_N-1:0] clk_en;

  pmc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pmc_req_arb u_arb (
    .accept_i (in_run),
    .req_sb_i (req_stby_i),
    .req_sp_i (req_susp_i),
    .req_hb_i (req_hibr_i),
    .vld_o    (req_vld),
    .mode_o   (req_mode)
  );

  pmc_seq #(.WAKE_GAP(WAKE_GAP)) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .req_vld_i  (req_vld),
    .req_mode_i (req_mode),
    .bus_idle_i (bus_idle_i),
    .irq_i      (irq_i),
    .pwr_btn_i  (pwr_btn_i),
    .wut_irq_i  (wut_irq_i),
    .in_run_o   (in_run),
    .clk_en_o   (clk_en),
    .sref_o     (sref_req_o),
    .stall_o    (stall_o),
    .mode_o     (cur_mode)
  );

  assign core_clk_en_o = clk_en[CK_CORE];
  assign tmr_clk_en_o  = clk_en[CK_TMR];
  assign int_clk_en_o  = clk_en[CK_INT];
  assign pll_en_o      = clk_en[CK_PLL];
  assign pbus_clk_en_o = clk_en[CK_PBUS];
  assign mclk_en_o     = clk_en[CK_MCLK];
  assign mode_o        = cur_mode;

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sb, sp, hb, idle, irq, pwr, wut;
  logic core_en, tmr_en, int_en, pll_en, pbus_en, mclk_en, sref, stall;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit armed  = 1'b0;
  string ctx = "R1";

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.WAKE_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_stby_i(sb), .req_susp_i(sp), .req_hibr_i(hb),
    .bus_idle_i(idle), .irq_i(irq), .pwr_btn_i(pwr), .wut_irq_i(wut),
    .core_clk_en_o(core_en), .tmr_clk_en_o(tmr_en), .int_clk_en_o(int_en),
    .pll_en_o(pll_en), .pbus_clk_en_o(pbus_en), .mclk_en_o(mclk_en),
    .sref_req_o(sref), .stall_o(stall), .mode_o(mode)
  );

  // reference model: expected output word {mode, stall, sref, mclk, pbus, pll, int, tmr, core}
  int  m_mode;
  int  m_where;   // 0 run, 1..3 entering, 4 resting low, 9 ramping
  int  m_tick;    // position inside an entry or ramp
  int  m_wait;
  bit  e_core, e_tmr, e_int, e_pll, e_pbus, e_mclk, e_sref, e_stall;

  task automatic model_reset();
    m_mode = 0; m_where = 0; m_tick = 0; m_wait = 0;
    {e_core, e_tmr, e_int, e_pll, e_pbus, e_mclk} = 6'b111111;
    e_sref = 0; e_stall = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit go;
      go = (m_where == 4) &&
           ((m_mode == 3) ? (pwr || wut) : (irq || wut));
      if (go) begin
        m_where = 9; m_tick = 0; m_wait = 0; e_pll = 1;
      end else if (m_where == 0) begin
        if (hb || sp || sb) begin
          m_mode = hb ? 3 : (sp ? 2 : 1);
          e_stall = 1; m_where = 1; m_tick = 0;
        end
      end else if (m_where == 1) begin
        if (m_mode == 1) begin
          e_core = 0; m_where = 4;
        end else if (m_tick == 0) begin
          e_pbus = 0; m_tick = 1;
        end else if (m_tick == 1) begin
          if (idle) begin
            if (m_mode == 2) begin e_sref = 1; m_tick = 2; end
            else begin
              {e_core, e_tmr, e_int, e_pll, e_pbus, e_mclk} = 6'b0;
              m_where = 4;
            end
          end
        end else begin
          e_core = 0; m_where = 4;
        end
      end else if (m_where == 9) begin
        m_wait++;
        if (m_wait == GAP) begin
          m_wait = 0; m_tick++;
          case (m_tick)
            1: begin e_tmr = 1; e_int = 1; end
            2: e_mclk = 1;
            3: e_pbus = 1;
            4: e_sref = 0;
            5: e_core = 1;
            default: begin e_stall = 0; m_mode = 0; m_where = 0; end
          endcase
        end
      end
    end
  end

  function automatic logic [9:0] got_w();
    return {mode, stall, sref, mclk_en, pbus_en, pll_en, int_en, tmr_en, core_en};
  endfunction

  function automatic logic [9:0] exp_w();
    return {m_mode[1:0], e_stall, e_sref, e_mclk, e_pbus, e_pll, e_int, e_tmr, e_core};
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (armed) check(ctx, got_w(), exp_w());
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit a, input bit b, input bit c);
    sb = a; sp = b; hb = c;
    tick(1);
    sb = 0; sp = 0; hb = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 60 && m_where != 0; i++) tick(1);
    tick(2);
  endtask

  initial begin
    rst_n = 1'b0;
    {sb, sp, hb, irq, pwr, wut} = '0;
    idle = 1'b1;
    tick(2);
    armed = 1'b1;
    ctx = "R1 reset";
    tick(2);
    check("R1 reset outputs", got_w(), 10'b00_0_0_111111);
    rst_n = 1'b1;
    tick(4);

    ctx = "R3 standby entry";
    strobe(1, 0, 0);
    check("R2 standby code", {8'd0, mode}, 10'd1);
    tick(3);
    ctx = "R4 standby irq exit / R9 ramp";
    irq = 1; tick(1); irq = 0;
    settle();

    ctx = "R4 standby timer exit";
    strobe(1, 0, 0);
    tick(3);
    wut = 1; tick(1); wut = 0;
    settle();

    ctx = "R5 suspend drain";
    idle = 0;
    strobe(0, 1, 0);
    tick(5);
    check("R5 held before idle", {8'd0, sref, core_en}, 10'b01);
    idle = 1;
    tick(4);
    ctx = "R6 suspend rest";
    check("R6 suspend domains", got_w(), 10'b10_1_1_101110);
    irq = 1; tick(1); irq = 0;
    settle();

    ctx = "R7 hibernate entry";
    idle = 0;
    strobe(0, 0, 1);
    tick(3);
    idle = 1;
    tick(3);
    ctx = "R8 irq ignored in hibernate";
    irq = 1; tick(4); irq = 0;
    check("R8 still hibernate", got_w(), 10'b11_1_0_000000);
    ctx = "R10 strobe in hibernate";
    strobe(1, 1, 0);
    tick(2);
    check("R10 strobe ignored", {8'd0, mode}, 10'd3);
    ctx = "R8 power button exit";
    pwr = 1; tick(1); pwr = 0;
    settle();

    ctx = "R8 wake timer exit";
    strobe(0, 0, 1);
    tick(5);
    wut = 1; tick(1); wut = 0;
    tick(3);
    ctx = "R10 strobes during ramp";
    strobe(1, 1, 1);
    settle();

    ctx = "R11 suspend over standby";
    strobe(1, 1, 0);
    check("R11 suspend wins", {8'd0, mode}, 10'd2);
    tick(4);
    irq = 1; tick(1); irq = 0;
    settle();

    ctx = "R11 hibernate over all";
    strobe(1, 1, 1);
    check("R11 hibernate wins", {8'd0, mode}, 10'd3);
    tick(4);
    pwr = 1; tick(1); pwr = 0;
    settle();

    ctx = "R12 wake held during entry";
    idle = 0;
    irq = 1;
    strobe(0, 1, 0);
    tick(3);
    check("R12 no early wake", {8'd0, mode, stall}, 10'b101);
    idle = 1;
    tick(3);
    irq = 0;
    ctx = "R10 strobe during suspend entry";
    settle();

    ctx = "R10 strobe during entry";
    strobe(1, 0, 0);
    strobe(0, 0, 1);
    tick(1);
    check("R10 entry not redirected", {8'd0, mode}, 10'd1);
    wut = 1; tick(1); wut = 0;
    settle();
    check("R9 back to full", got_w(), 10'b00_0_0_111111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule